// File: doc/BRIEF.md
# Fall-Through Shift FIFO with Ready-Flag Handshake

This block is a first-in first-out buffer of 64 words of 5 bits, built as a chain of single-word stages: one input stage, 62 inner stages and one output stage. There are no read or write pointers. A written word drops one stage per clock toward the output whenever the stage ahead of it is empty. When a word leaves, the free slot moves back toward the input one stage per clock in the same way. The two ends work independently. The write side uses a shift-in strobe with an input-ready flag, and the read side uses a shift-out strobe with an output-ready flag.

Both strobes are sampled on the clock. One strobe pulse moves at most one word. After a transfer, the stage at that end stays blocked until its strobe has been seen low. A strobe held high therefore performs exactly one automatic transfer as soon as the flag at that end allows it, and the flag shows a one-cycle pulse when this happens. For this reason two instances can be chained into a deeper buffer with no extra logic: the first instance's output-ready drives the second's shift-in, the second's input-ready drives the first's shift-out, and data passes straight across.

An asynchronous active-low reset empties the buffer. An active-low output enable either shows the output-stage word or forces the data pins to zero, and a separate enable output reports which of the two applies.

Top module: `ripple_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises, `in_ready` is 1, `out_ready` is 0 and `dout` is all zeros, with `oe_n` low. This also holds when reset is asserted while the buffer is full.
- R2: A rising clock edge that samples `shift_in` = 1 while `in_ready` = 1 captures `din`, and `in_ready` is 0 after that edge. `in_ready` stays 0 until an edge has sampled `shift_in` = 0 and the word has left the input stage.
- R3: Holding `shift_in` high for many cycles loads exactly one word.
- R4: An edge that samples `shift_out` = 1 while `out_ready` = 1 removes the word, and `out_ready` is 0 after that edge. The next word does not enter the output stage while `shift_out` stays high. It arrives, with `out_ready` = 1, on the second edge after `shift_out` is driven low.
- R5: Words leave in the order they were written, and `dout` shows the output-stage word.
- R6: The buffer holds 64 words. When it is full, `in_ready` stays 0 and further `shift_in` pulses are ignored, so exactly the first 64 words are read back.
- R7: When the buffer is empty, `out_ready` stays 0, `shift_out` pulses have no effect, and `dout` keeps the last word that reached the output stage.
- R8: With `shift_out` held high on an empty buffer, a word that reaches the output stage raises `out_ready` for exactly one cycle and is then removed. `dout` still shows that word afterwards.
- R9: With `shift_in` held high on a full buffer, a free slot that reaches the input stage raises `in_ready` for exactly one cycle. The waiting `din` is loaded and comes out last.
- R10: A single word written into an empty buffer raises `out_ready` on the 64th (DEPTH-th) rising edge, counting from the first edge that samples `shift_in` = 0 after the write. Each word advances at most one stage per clock.
- R11: With `oe_n` = 1, `dout` is all zeros and `dout_en` is 0, and the stored contents and flags are unchanged. With `oe_n` = 0, `dout_en` is 1.
- R12: Two instances chained flag-to-strobe and data-to-data hold 128 words in order, and the first instance's `in_ready` is 0 once all 128 words are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_in | input | 1 | Write strobe, sampled each clock |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | Input stage empty, a write can be accepted |
| shift_out | input | 1 | Read strobe, sampled each clock |
| out_ready | output | 1 | Output stage holds a valid word |
| oe_n | input | 1 | Output enable, active low |
| dout | output | WIDTH | Output-stage word, zero while disabled |
| dout_en | output | 1 | High when `dout` carries the output-stage word |

## Verification
Suppose the occupancy of an inner stage is lost or duplicated. The output would then show a missing, repeated or reordered word, or an `out_ready` rise earlier or later than the stage-by-stage travel time. The bench's word-and-position model would catch this at the first cycle the flag or data differs, at most 64 clocks after the fault. A blocking hold that clears too early or too late changes the width of the one-cycle flag pulses in the held-strobe cases, or lets a held strobe move two words, and either is visible within a single cycle at `in_ready` or `out_ready`. The chained pair shows whether two instances agree on the flag-to-strobe timing: a wrong count or order appears at the far end after the full 128-word fill and drain.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

   // State reported by one strobe controller: a transfer happens this cycle,
   // and the end is still blocked by an earlier transfer.
   typedef struct packed {
      logic fire;
      logic hold;
   } strobe_hs_t;

endpackage

// File: rtl/ripple_fifo_strobe.sv
module ripple_fifo_strobe
   import ripple_fifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_i,
   input  logic       avail_i,
   output strobe_hs_t hs_o
);

   logic hold_q;
   logic fire;

   // A transfer needs the strobe high, the end free to move, and no
   // earlier transfer still waiting for the strobe to drop.
   always_comb begin
      fire      = strobe_i & ~hold_q & avail_i;
      hs_o.fire = fire;
      hs_o.hold = hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else begin
         hold_q <= strobe_i & (hold_q | fire);
      end
   end

endmodule

// File: rtl/ripple_fifo_stage.sv
module ripple_fifo_stage #(
   parameter int WIDTH      = 5,
   parameter bit CLEAR_DATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             unload_i,
   input  logic [WIDTH-1:0] d_i,
   output logic             full_o,
   output logic [WIDTH-1:0] q_o
);

   logic             full_q;
   logic [WIDTH-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else begin
         full_q <= load_i | (full_q & ~unload_i);
      end
   end

   // Data registers are cleared by reset only where a parameter asks for it.
   generate
      if (CLEAR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
            end else if (load_i) begin
               data_q <= d_i;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (load_i) begin
               data_q <= d_i;
            end
         end
      end
   endgenerate

   assign full_o = full_q;
   assign q_o    = data_q;

endmodule

// File: rtl/ripple_fifo_outdrv.sv
module ripple_fifo_outdrv #(
   parameter int WIDTH = 5
) (
   input  logic             oe_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             en_o
);

   assign q_o  = oe_n_i ? '0 : d_i;
   assign en_o = ~oe_n_i;

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
   import ripple_fifo_pkg::*;
#(
   parameter int WIDTH     = 5,
   parameter int DEPTH     = 64,
   parameter bit CLEAR_ALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_in,
   input  logic [WIDTH-1:0] din,
   output logic             in_ready,
   input  logic             shift_out,
   output logic             out_ready,
   input  logic             oe_n,
   output logic [WIDTH-1:0] dout,
   output logic             dout_en
);

   localparam int LAST = DEPTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ripple_fifo: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("ripple_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] full;
   logic [DEPTH-1:0] load_v;
   logic [DEPTH-1:0] unload_v;
   logic [LAST-1:0]  adv;
   logic [WIDTH-1:0] stage_d [DEPTH];
   logic [WIDTH-1:0] stage_q [DEPTH];

   strobe_hs_t       in_hs;
   strobe_hs_t       out_hs;
   logic             push_fire;
   logic             pop_fire;
   logic             in_hold;
   logic             out_hold;
   logic [WIDTH-1:0] out_word;

   ripple_fifo_strobe u_in_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (shift_in),
      .avail_i  (~full[0]),
      .hs_o     (in_hs)
   );

   ripple_fifo_strobe u_out_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (shift_out),
      .avail_i  (full[LAST]),
      .hs_o     (out_hs)
   );

   assign push_fire = in_hs.fire;
   assign in_hold   = in_hs.hold;
   assign pop_fire  = out_hs.fire;
   assign out_hold  = out_hs.hold;

   // A word moves forward when the stage ahead was empty at the start of the
   // cycle. The two end stages are also blocked by their pending holds.
   generate
      for (genvar i = 0; i < LAST; i++) begin : g_adv
         logic blk_lo;
         logic blk_hi;
         if (i == 0) begin : g_lo_hold
            assign blk_lo = in_hold;
         end else begin : g_lo_free
            assign blk_lo = 1'b0;
         end
         if (i == LAST - 1) begin : g_hi_hold
            assign blk_hi = out_hold;
         end else begin : g_hi_free
            assign blk_hi = 1'b0;
         end
         assign adv[i] = full[i] & ~full[i+1] & ~blk_lo & ~blk_hi;
      end

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         localparam bit CLR = CLEAR_ALL || (i == LAST);
         if (i == 0) begin : g_head
            assign load_v[i]  = push_fire;
            assign stage_d[i] = din;
         end else begin : g_body
            assign load_v[i]  = adv[i-1];
            assign stage_d[i] = stage_q[i-1];
         end
         if (i == LAST) begin : g_tail
            assign unload_v[i] = pop_fire;
         end else begin : g_pass
            assign unload_v[i] = adv[i];
         end
         ripple_fifo_stage #(
            .WIDTH      (WIDTH),
            .CLEAR_DATA (CLR)
         ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_v[i]),
            .unload_i (unload_v[i]),
            .d_i      (stage_d[i]),
            .full_o   (full[i]),
            .q_o      (stage_q[i])
         );
      end
   endgenerate

   assign in_ready  = ~full[0];
   assign out_ready = full[LAST];
   assign out_word  = stage_q[LAST];

   ripple_fifo_outdrv #(
      .WIDTH (WIDTH)
   ) u_outdrv (
      .oe_n_i (oe_n),
      .d_i    (out_word),
      .q_o    (dout),
      .en_o   (dout_en)
   );

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
   parameter int WIDTH = 5,
   parameter int DEPTH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shift_in,
   input logic             shift_out,
   input logic             in_ready,
   input logic             out_ready,
   input logic             oe_n,
   input logic [WIDTH-1:0] dout,
   input logic             dout_en,
   input logic [DEPTH-1:0] full,
   input logic             push_fire,
   input logic             pop_fire,
   input logic             in_hold,
   input logic             out_hold,
   input logic [WIDTH-1:0] out_word
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
      end else begin
         seen <= 1'b1;
      end
   end

   // R2
   push_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_fire |=> !in_ready);

   // R2
   in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_hold |-> !in_ready);

   // R3
   one_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && shift_in) |-> !push_fire);

   // R4
   pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_fire |=> !out_ready);

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_hold && shift_out) |-> (!out_ready && !pop_fire));

   // R5
   occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ($countones(full) ==
                $past($countones(full)) + int'($past(push_fire)) - int'($past(pop_fire))));

   // R6
   full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(full) == DEPTH) |-> (!push_fire && !in_ready));

   // R7
   last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> (out_ready || $stable(out_word)));

   // R11
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (dout == '0 && !dout_en));

endmodule

bind ripple_fifo ripple_fifo_chk #(
   .WIDTH (WIDTH),
   .DEPTH (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shift_in  (shift_in),
   .shift_out (shift_out),
   .in_ready  (in_ready),
   .out_ready (out_ready),
   .oe_n      (oe_n),
   .dout      (dout),
   .dout_en   (dout_en),
   .full      (full),
   .push_fire (push_fire),
   .pop_fire  (pop_fire),
   .in_hold   (in_hold),
   .out_hold  (out_hold),
   .out_word  (out_word)
);

// File: tb/ripple_fifo_bench.sv
module ripple_fifo_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 5;
   localparam int D = 64;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         rst_n = 1'b0;
   logic         si = 1'b0, so = 1'b0, oe_n = 1'b0;
   logic [W-1:0] din = '0;
   logic         in_ready, out_ready, dout_en;
   logic [W-1:0] dout;

   ripple_fifo u_ripple_fifo (
      .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_ready(in_ready),
      .shift_out(so), .out_ready(out_ready), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
   );

   // Chained pair for R12
   logic         c_si = 1'b0, c_so = 1'b0;
   logic [W-1:0] c_din = '0;
   logic         c_in_ready, c_out_ready, ab_link, ba_link, a_en, b_en;
   logic [W-1:0] ab_data, c_dout;

   ripple_fifo u_casc_a (
      .clk(clk), .rst_n(rst_n), .shift_in(c_si), .din(c_din), .in_ready(c_in_ready),
      .shift_out(ba_link), .out_ready(ab_link), .oe_n(1'b0), .dout(ab_data), .dout_en(a_en)
   );
   ripple_fifo u_casc_b (
      .clk(clk), .rst_n(rst_n), .shift_in(ab_link), .din(ab_data), .in_ready(ba_link),
      .shift_out(c_so), .out_ready(c_out_ready), .oe_n(1'b0), .dout(c_dout), .dout_en(b_en)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   task automatic check_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Reference model: a queue of words, each with its stage position.
   int m_pos[$];
   int m_val[$];
   int m_old[$];
   bit m_hin, m_hout, m_push, m_pop, m_go;
   int m_last, m_n, m_lim;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pos.delete(); m_val.delete();
         m_hin = 1'b0; m_hout = 1'b0; m_last = 0;
      end else begin
         m_n = m_pos.size();
         m_push = si && !m_hin && ((m_n == 0) || (m_pos[m_n-1] != 0));
         m_pop  = so && !m_hout && (m_n > 0) && (m_pos[0] == D-1);
         m_old = m_pos;
         for (int k = 0; k < m_n; k++) begin
            m_lim = (k == 0) ? D : m_old[k-1];
            m_go = (m_old[k] + 1 < m_lim) && !(m_old[k] == 0 && m_hin)
                   && !(m_old[k] + 1 == D-1 && m_hout);
            if (m_go) begin
               m_pos[k] = m_old[k] + 1;
               if (m_pos[k] == D-1) m_last = m_val[k];
            end
         end
         if (m_pop) begin
            void'(m_pos.pop_front()); void'(m_val.pop_front());
         end
         if (m_push) begin
            m_pos.push_back(0); m_val.push_back(int'(din));
         end
         m_hin  = si && (m_hin || m_push);
         m_hout = so && (m_hout || m_pop);
      end
   end

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         m_n = m_pos.size();
         check_eq("R2", "in_ready vs model", int'(in_ready),
                  int'((m_n == 0) || (m_pos[m_n-1] != 0)));
         check_eq("R4", "out_ready vs model", int'(out_ready),
                  int'((m_n > 0) && (m_pos[0] == D-1)));
         check_eq("R5", "dout vs model", int'(dout), oe_n ? 0 : m_last);
         check_eq("R11", "dout_en vs model", int'(dout_en), int'(!oe_n));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_up();
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic write_word(int v);
      int t = 0;
      while (!in_ready && t < 1000) begin tick(); t++; end
      check_eq("R2", "write wait in_ready", int'(in_ready), 1);
      si = 1'b1; din = W'(v); tick(); si = 1'b0;
   endtask

   task automatic read_word(output int v);
      int t = 0;
      while (!out_ready && t < 1000) begin tick(); t++; end
      check_eq("R4", "read wait out_ready", int'(out_ready), 1);
      v = int'(dout); so = 1'b1; tick(); so = 1'b0; tick();
   endtask

   task automatic c_write(int v);
      int t = 0;
      while (!c_in_ready && t < 1000) begin tick(); t++; end
      check_eq("R12", "chain write wait", int'(c_in_ready), 1);
      c_si = 1'b1; c_din = W'(v); tick(); c_si = 1'b0; tick();
   endtask

   task automatic c_read(output int v);
      int t = 0;
      while (!c_out_ready && t < 1000) begin tick(); t++; end
      check_eq("R12", "chain read wait", int'(c_out_ready), 1);
      v = int'(c_dout); c_so = 1'b1; tick(); c_so = 1'b0; tick();
   endtask

   task automatic settle(int n);
      repeat (n) tick();
   endtask

   initial begin
      int v, n, pulses;
      settle(3);
      // R1 during and after reset
      check_eq("R1", "in_ready in reset", int'(in_ready), 1);
      check_eq("R1", "out_ready in reset", int'(out_ready), 0);
      check_eq("R1", "dout in reset", int'(dout), 0);
      rst_n = 1'b1; tick();
      check_eq("R1", "in_ready after reset", int'(in_ready), 1);
      check_eq("R1", "out_ready after reset", int'(out_ready), 0);

      // R10 latency of a lone word
      si = 1'b1; din = 5'd21; tick(); si = 1'b0;
      check_eq("R2", "in_ready after capture", int'(in_ready), 0);
      n = 0;
      while (!out_ready && n < 200) begin tick(); n++; end
      check_eq("R10", "edges until out_ready", n, D);
      check_eq("R5", "lone word value", int'(dout), 21);

      // R7 empty behaviour
      read_word(v);
      check_eq("R7", "read value", v, 21);
      repeat (3) begin so = 1'b1; tick(); so = 1'b0; tick(); end
      check_eq("R7", "out_ready stays low", int'(out_ready), 0);
      check_eq("R7", "last word kept", int'(dout), 21);

      // R3 held shift_in loads one word
      si = 1'b1; din = 5'd9; settle(10); si = 1'b0; settle(80);
      read_word(v);
      check_eq("R3", "held write value", v, 9);
      settle(80);
      check_eq("R3", "only one word loaded", int'(out_ready), 0);

      // R4 next word waits for shift_out low
      write_word(3); write_word(4); settle(150);
      so = 1'b1; tick();
      check_eq("R4", "out_ready after pop", int'(out_ready), 0);
      settle(5);
      check_eq("R4", "held so blocks next", int'(out_ready), 0);
      so = 1'b0; tick(); tick();
      check_eq("R4", "next word arrives", int'(out_ready), 1);
      check_eq("R4", "next word value", int'(dout), 4);
      read_word(v);

      // R5 / R6 fill to capacity, overflow ignored
      for (int i = 0; i < D; i++) write_word((i * 11 + 7) % 32);
      settle(200);
      check_eq("R6", "in_ready when full", int'(in_ready), 0);
      repeat (3) begin si = 1'b1; din = 5'd31; tick(); si = 1'b0; tick(); end
      check_eq("R6", "in_ready after overflow", int'(in_ready), 0);
      for (int i = 0; i < D; i++) begin
         read_word(v);
         check_eq("R5", "drain order", v, (i * 11 + 7) % 32);
      end
      settle(10);
      check_eq("R6", "empty after 64 reads", int'(out_ready), 0);

      // R9 held shift_in on a full buffer
      for (int i = 0; i < D; i++) write_word(i ^ 5);
      settle(200);
      si = 1'b1; din = 5'd17;
      read_word(v);
      check_eq("R9", "first word out", v, 5);
      pulses = 0;
      repeat (200) begin tick(); if (in_ready) pulses++; end
      check_eq("R9", "in_ready pulse count", pulses, 1);
      si = 1'b0; tick();
      for (int i = 1; i < D; i++) begin
         read_word(v);
         check_eq("R9", "old word order", v, (i ^ 5) % 32);
      end
      read_word(v);
      check_eq("R9", "waiting word last", v, 17);

      // R8 held shift_out on an empty buffer
      settle(5);
      so = 1'b1;
      write_word(13);
      pulses = 0;
      repeat (150) begin tick(); if (out_ready) pulses++; end
      check_eq("R8", "out_ready pulse count", pulses, 1);
      check_eq("R8", "word still shown", int'(dout), 13);
      so = 1'b0; tick();
      check_eq("R8", "empty after auto read", int'(out_ready), 0);

      // R11 output enable
      write_word(22); settle(100);
      oe_n = 1'b1; tick();
      check_eq("R11", "dout disabled", int'(dout), 0);
      check_eq("R11", "dout_en disabled", int'(dout_en), 0);
      check_eq("R11", "state kept", int'(out_ready), 1);
      oe_n = 1'b0; tick();
      check_eq("R11", "dout enabled", int'(dout), 22);
      read_word(v);

      // R1 reset while holding data
      write_word(1); write_word(2); write_word(3); settle(100);
      rst_n = 1'b0; #1;
      check_eq("R1", "in_ready mid reset", int'(in_ready), 1);
      check_eq("R1", "out_ready mid reset", int'(out_ready), 0);
      check_eq("R1", "dout mid reset", int'(dout), 0);
      tick(); rst_n = 1'b1; tick();

      // R12 chained pair
      for (int i = 0; i < 2 * D; i++) c_write((i * 5 + 1) % 32);
      settle(400);
      check_eq("R12", "chain full", int'(c_in_ready), 0);
      for (int i = 0; i < 2 * D; i++) begin
         c_read(v);
         check_eq("R12", "chain order", v, (i * 5 + 1) % 32);
      end
      settle(300);
      check_eq("R12", "chain empty", int'(c_out_ready), 0);

      finish_up();
   end

endmodule